// File: doc/BRIEF.md
# Mixed-Divisor Video Line Timing Generator

This block turns a single master clock into the horizontal and vertical timing of a 60 Hz, 262-line field. It does not emit a slower clock. Instead it raises a one-cycle dot enable, `dot_ce`, every 4 or every 5 master clocks. The choice follows the position inside the sync pulse. Shortly after the sync output falls, dots stretch to 5 master clocks. They stay stretched for three dots after sync is released, then return to 4.

A dot counter and a line counter advance on that enable. The following outputs are decoded from the counters:
- active-low horizontal sync
- active-low vertical sync
- active-low composite sync
- a display-enable strobe that frames the drawn picture

A vertical interrupt request sets at a fixed dot on the first line after the picture. It holds until the consumer pulses the acknowledge input.

Ordinary lines are 840 dots and 3420 master clocks long. The nine lines at the top of the field carry two narrow sync pulses each, 420 dots apart. Each of those pulses has its own slow stretch, so those lines come out at 3424 master clocks.

Top module: `mdt_line_timer`

## Requirements
- R1: While `rst` is high at a rising clock edge, the dot and line counters return to dot 0 of line 0, the divider phase clears to the 4-clock rate, and `vint_req` clears. In the first cycle after reset, `hsync_n`=0, `vsync_n`=1, `csync_n`=0, `disp_en`=0, `vint_req`=0 and `dot_ce`=0.
- R2: On lines V_EQ_LINES..V_TOTAL-1, successive falls of `hsync_n` are 840 `dot_ce` pulses and 3420 master clocks apart.
- R3: On those lines `hsync_n` stays low for 64 dots: 7 dots of 4 clocks, then 57 dots of 5 clocks, 313 clocks in total. The 3 dots after its release also take 5 clocks each.
- R4: On lines 0..V_EQ_LINES-1, `hsync_n` falls at dot 0 and again at dot 420, 420 dots and 1712 clocks apart. Each pulse is 32 dots (3 at 4 clocks, 29 at 5 clocks), 157 clocks low. Each release is followed by 3 dots of 5 clocks.
- R5: `disp_en` is high only on lines V_FIRST..V_FIRST+V_ACTIVE-1. On those lines it rises at dot 154, 676 clocks after the line's sync fall, and stays high for 640 dots (2560 clocks). Exactly V_ACTIVE lines per field carry it.
- R6: `vsync_n` is low for the whole of lines V_BROAD_FIRST..V_BROAD_FIRST+V_BROAD_LINES-1 (default lines 3, 4 and 5). It falls together with that first line's sync fall and rises with the sync fall of the line after the last one.
- R7: `csync_n` equals `hsync_n` wherever `vsync_n` is high. On lines where `vsync_n` is low, `csync_n` is the AND of `hsync_n` with a vertical pattern. That pattern is high only in the last 32 dots of each half line, so each high run of `csync_n` lasts 128 clocks.
- R8: `vint_req` rises at dot 104 of line V_FIRST+V_ACTIVE (default 255), 476 clocks after that line's sync fall. This is 40 dots after the sync release: 3 dots of 5 clocks, then 37 dots of 4 clocks. It rises once per field.
- R9: Once set, `vint_req` stays high until `vint_ack` is sampled high, and it is low one clock after that sample. An acknowledge while the request is low has no effect. An acknowledge sampled at the same edge as the trigger leaves the request set.
- R10: A field is V_TOTAL lines, after which the line counter returns to line 0. With the defaults this is (262-9)*3420 + 9*3424 = 896076 master clocks from one line-0 sync fall to the next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| vint_ack | input | 1 | One-cycle acknowledge that clears the vertical interrupt request |
| dot_ce | output | 1 | Dot enable, high in the last master clock of every dot |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| csync_n | output | 1 | Composite sync, active low |
| disp_en | output | 1 | High while a drawn picture dot is on the line |
| vint_req | output | 1 | Vertical interrupt request, held until acknowledged |

## Verification
Sync, display enable and composite sync are decoded without registers from the dot and line counters. Each of them therefore changes in the same cycle as the rising edge on which the counter steps, and that edge ends a dot, so every expected interval is a whole count of master clocks. The interrupt request is a register that sets on the edge at which the dot counter reaches 104, so it moves in step with the counters. An acknowledge driven just after one edge is sampled at the next edge, and its effect shows in the cycle after that edge.

The bench samples on falling edges and counts rising edges between the transitions it observes. It compares each gap with the expected clock count and checks the line position at the moment of each transition.

// File: rtl/mdt_pkg.sv
package mdt_pkg;

  // horizontal segments in dots, counted from the sync fall
  localparam int SYNC_FULL      = 64;
  localparam int SYNC_FULL_FAST = 7;
  localparam int SYNC_HALF      = 32;
  localparam int SYNC_HALF_FAST = 3;
  localparam int SLOW_TAIL      = 3;
  localparam int POST_SYNC      = 64;
  localparam int BORDER_L       = 26;
  localparam int ACTIVE_W       = 640;
  localparam int BORDER_R       = 28;
  localparam int BACK_PORCH     = 18;
  localparam int VINT_AFTER     = 40;

  localparam int H_TOTAL   = SYNC_FULL + POST_SYNC + BORDER_L + ACTIVE_W + BORDER_R + BACK_PORCH;
  localparam int HALF_LINE = H_TOTAL / 2;
  localparam int ACT_FIRST = SYNC_FULL + POST_SYNC + BORDER_L;
  localparam int VINT_DOT  = SYNC_FULL + VINT_AFTER;
  localparam int SERR_W    = SYNC_HALF;

  // slow run lengths (stretched part of the pulse plus the lag after release)
  localparam int SLOW_RUN_FULL = SYNC_FULL - SYNC_FULL_FAST + SLOW_TAIL;
  localparam int SLOW_RUN_HALF = SYNC_HALF - SYNC_HALF_FAST + SLOW_TAIL;

  function automatic logic in_span(input int x, input int lo, input int len);
    return (x >= lo) && (x < lo + len);
  endfunction

  // true while the horizontal sync output is held low
  function automatic logic sync_low(input int h, input logic half);
    if (half)
      return in_span(h, 0, SYNC_HALF) || in_span(h, HALF_LINE, SYNC_HALF);
    return in_span(h, 0, SYNC_FULL);
  endfunction

  // true for dots that take the long divisor
  function automatic logic dot_slow(input int h, input logic half);
    if (half)
      return in_span(h, SYNC_HALF_FAST, SLOW_RUN_HALF) ||
             in_span(h, HALF_LINE + SYNC_HALF_FAST, SLOW_RUN_HALF);
    return in_span(h, SYNC_FULL_FAST, SLOW_RUN_FULL);
  endfunction

  // vertical pattern on broad lines: low except a serration window ending each half line
  function automatic logic broad_low(input int h);
    return !(in_span(h, HALF_LINE - SERR_W, SERR_W) || in_span(h, H_TOTAL - SERR_W, SERR_W));
  endfunction

  function automatic logic picture_dot(input int h);
    return in_span(h, ACT_FIRST, ACTIVE_W);
  endfunction

endpackage

// File: rtl/mdt_dotdiv.sv
module mdt_dotdiv #(
  parameter int DIV_FAST = 4,
  parameter int DIV_SLOW = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic slow,
  output logic dot_ce
);
  localparam int PW = $clog2(DIV_SLOW);

  logic [PW-1:0] ph_q;
  logic [PW-1:0] ph_last;

  // the divisor follows the current dot, which only changes on dot_ce
  assign ph_last = slow ? PW'(DIV_SLOW - 1) : PW'(DIV_FAST - 1);
  assign dot_ce  = (ph_q == ph_last);

  always_ff @(posedge clk) begin
    if (rst)         ph_q <= '0;
    else if (dot_ce) ph_q <= '0;
    else             ph_q <= ph_q + 1'b1;
  end
endmodule

// File: rtl/mdt_scan.sv
module mdt_scan #(
  parameter int H_TOTAL = 840,
  parameter int V_TOTAL = 262,
  parameter int HW      = 10,
  parameter int VW      = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dot_ce,
  output logic [HW-1:0] h_o,
  output logic [VW-1:0] v_o
);
  logic h_wrap;
  logic v_wrap;

  assign h_wrap = (h_o == HW'(H_TOTAL - 1));
  assign v_wrap = (v_o == VW'(V_TOTAL - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      h_o <= '0;
      v_o <= '0;
    end else if (dot_ce) begin
      if (h_wrap) begin
        h_o <= '0;
        v_o <= v_wrap ? '0 : v_o + 1'b1;
      end else begin
        h_o <= h_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mdt_decode.sv
module mdt_decode #(
  parameter int V_FIRST       = 31,
  parameter int V_ACTIVE      = 224,
  parameter int V_EQ_LINES    = 9,
  parameter int V_BROAD_FIRST = 3,
  parameter int V_BROAD_LINES = 3,
  parameter int HW            = 10,
  parameter int VW            = 9
) (
  input  logic [HW-1:0] h_i,
  input  logic [VW-1:0] v_i,
  output logic          slow_o,
  output logic          hsync_n_o,
  output logic          vsync_n_o,
  output logic          csync_n_o,
  output logic          disp_en_o
);
  int   hi;
  int   vi;
  logic half_line;
  logic broad_line;
  logic picture_row;
  logic vpat_n;

  always_comb begin
    hi          = int'(h_i);
    vi          = int'(v_i);
    half_line   = vi < V_EQ_LINES;
    broad_line  = mdt_pkg::in_span(vi, V_BROAD_FIRST, V_BROAD_LINES);
    picture_row = mdt_pkg::in_span(vi, V_FIRST, V_ACTIVE);
    slow_o      = mdt_pkg::dot_slow(hi, half_line);
    hsync_n_o   = !mdt_pkg::sync_low(hi, half_line);
    vpat_n      = !(broad_line && mdt_pkg::broad_low(hi));
    vsync_n_o   = !broad_line;
    csync_n_o   = hsync_n_o & vpat_n;
    disp_en_o   = picture_row && mdt_pkg::picture_dot(hi);
  end
endmodule

// File: rtl/mdt_vint.sv
module mdt_vint #(
  parameter int HW        = 10,
  parameter int VW        = 9,
  parameter int VINT_LINE = 255,
  parameter int VINT_DOT  = 104
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dot_ce,
  input  logic [HW-1:0] h_i,
  input  logic [VW-1:0] v_i,
  input  logic          ack_i,
  output logic          trig_o,
  output logic          req_o
);
  // the request sets on the edge at which the dot counter steps onto VINT_DOT
  assign trig_o = dot_ce && (v_i == VW'(VINT_LINE)) && (h_i == HW'(VINT_DOT - 1));

  always_ff @(posedge clk) begin
    if (rst)         req_o <= 1'b0;
    else if (trig_o) req_o <= 1'b1;
    else if (ack_i)  req_o <= 1'b0;
  end
endmodule

// File: rtl/mdt_line_timer.sv
module mdt_line_timer #(
  parameter int V_TOTAL       = 262,
  parameter int V_FIRST       = 31,
  parameter int V_ACTIVE      = 224,
  parameter int V_EQ_LINES    = 9,
  parameter int V_BROAD_FIRST = 3,
  parameter int V_BROAD_LINES = 3,
  parameter int DIV_FAST      = 4,
  parameter int DIV_SLOW      = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic vint_ack,
  output logic dot_ce,
  output logic hsync_n,
  output logic vsync_n,
  output logic csync_n,
  output logic disp_en,
  output logic vint_req
);
  localparam int H_TOTAL   = mdt_pkg::H_TOTAL;
  localparam int HW        = $clog2(H_TOTAL);
  localparam int VW        = $clog2(V_TOTAL);
  localparam int VINT_LINE = V_FIRST + V_ACTIVE;

  logic [HW-1:0] h_cnt;
  logic [VW-1:0] v_cnt;
  logic          dot_slow;
  logic          vint_trig;

  mdt_dotdiv #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) u_div (
    .clk(clk), .rst(rst), .slow(dot_slow), .dot_ce(dot_ce)
  );

  mdt_scan #(.H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL), .HW(HW), .VW(VW)) u_scan (
    .clk(clk), .rst(rst), .dot_ce(dot_ce), .h_o(h_cnt), .v_o(v_cnt)
  );

  mdt_decode #(
    .V_FIRST(V_FIRST), .V_ACTIVE(V_ACTIVE), .V_EQ_LINES(V_EQ_LINES),
    .V_BROAD_FIRST(V_BROAD_FIRST), .V_BROAD_LINES(V_BROAD_LINES),
    .HW(HW), .VW(VW)
  ) u_dec (
    .h_i(h_cnt), .v_i(v_cnt), .slow_o(dot_slow),
    .hsync_n_o(hsync_n), .vsync_n_o(vsync_n), .csync_n_o(csync_n), .disp_en_o(disp_en)
  );

  mdt_vint #(.HW(HW), .VW(VW), .VINT_LINE(VINT_LINE), .VINT_DOT(mdt_pkg::VINT_DOT)) u_vint (
    .clk(clk), .rst(rst), .dot_ce(dot_ce), .h_i(h_cnt), .v_i(v_cnt),
    .ack_i(vint_ack), .trig_o(vint_trig), .req_o(vint_req)
  );
endmodule

// File: rtl/mdt_checker.sv
module mdt_checker #(
  parameter int HW        = 10,
  parameter int VW        = 9,
  parameter int VINT_LINE = 255
) (
  input logic          clk,
  input logic          rst,
  input logic [HW-1:0] h,
  input logic [VW-1:0] v,
  input logic          dot_ce,
  input logic          slow,
  input logic          trig,
  input logic          ack,
  input logic          irq,
  input logic          hsync_n,
  input logic          vsync_n,
  input logic          de
);
  // R1: reset returns the counters and the request to their start values
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (h == '0 && v == '0 && !irq));

  // R2: the dot counter steps by one or wraps, and only on a dot enable
  a_r2_dot_step: assert property (@(posedge clk) disable iff (rst)
    dot_ce |=> (h == '0 || h == $past(h) + 1'b1));
  a_r2_dot_hold: assert property (@(posedge clk) disable iff (rst)
    !dot_ce |=> $stable(h));

  // R3: the dot that starts a sync pulse runs at the short divisor
  a_r3_head_fast: assert property (@(posedge clk) disable iff (rst)
    $fell(hsync_n) |-> !slow);

  // R4: the dot after any sync release still runs at the long divisor
  a_r4_tail_slow: assert property (@(posedge clk) disable iff (rst)
    $rose(hsync_n) |-> slow);

  // R5: no picture while either sync is asserted
  a_r5_de_outside_sync: assert property (@(posedge clk) disable iff (rst)
    de |-> (hsync_n && vsync_n));

  // R8: the request appears only at the trigger position
  a_r8_vint_position: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> (v == VW'(VINT_LINE) && h == HW'(mdt_pkg::VINT_DOT)));

  // R9: held until acknowledged, cleared after acknowledge, trigger wins a tie
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (irq && !ack) |=> irq);
  a_r9_clear: assert property (@(posedge clk) disable iff (rst)
    (irq && ack && !trig) |=> !irq);
  a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
    trig |=> irq);
endmodule

bind mdt_line_timer mdt_checker #(.HW(HW), .VW(VW), .VINT_LINE(VINT_LINE)) u_chk (
  .clk(clk), .rst(rst), .h(h_cnt), .v(v_cnt), .dot_ce(dot_ce), .slow(dot_slow),
  .trig(vint_trig), .ack(vint_ack), .irq(vint_req), .hsync_n(hsync_n),
  .vsync_n(vsync_n), .de(disp_en)
);

// File: tb/tb_mdt_line_timer.sv
`timescale 1ns/1ps
module tb_mdt_line_timer;
  // shortened field so a whole field fits the run
  localparam int NV     = 36;
  localparam int NFIRST = 12;
  localparam int NACT   = 16;
  localparam int NEQ    = 9;
  localparam int NBRD   = 3;
  localparam int VLINE  = NFIRST + NACT;

  // expected clock counts, built from the dot splits in the requirements
  localparam int P_FULL   = 7*4 + 57*5;                    // 313
  localparam int L_FULL   = P_FULL + 3*5 + (840-67)*4;     // 3420
  localparam int P_HALF   = 3*4 + 29*5;                    // 157
  localparam int GAP_HALF = P_HALF + 3*5 + (420-35)*4;     // 1712
  localparam int DE_OFF   = P_FULL + 3*5 + (154-67)*4;     // 676
  localparam int DE_W     = 640*4;
  localparam int VI_OFF   = P_FULL + 3*5 + 37*4;           // 476
  localparam int SERR     = 32*4;
  localparam int VS_W     = 3*2*GAP_HALF;
  localparam int FIELD    = (NV-NEQ)*L_FULL + NEQ*2*GAP_HALF;
  localparam int FALLS    = NV + NEQ;
  localparam int TRIG_REL = NEQ*2*GAP_HALF + (VLINE-NEQ)*L_FULL + VI_OFF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vint_ack = 1'b0;
  logic dot_ce, hsync_n, vsync_n, csync_n, disp_en, vint_req;

  mdt_line_timer #(.V_TOTAL(NV), .V_FIRST(NFIRST), .V_ACTIVE(NACT), .V_EQ_LINES(NEQ),
                   .V_BROAD_FIRST(3), .V_BROAD_LINES(NBRD)) dut (
    .clk(clk), .rst(rst), .vint_ack(vint_ack), .dot_ce(dot_ce), .hsync_n(hsync_n),
    .vsync_n(vsync_n), .csync_n(csync_n), .disp_en(disp_en), .vint_req(vint_req)
  );

  always #10 clk = ~clk;

  int unsigned cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0;
  int bad = 0;
  bit started = 0;
  bit done = 0;
  int unsigned t0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // monitor state
  bit p_hs, p_vs, p_cs, p_de, p_irq, p_ack;
  int fi, line, dots, de_lines, vint_cnt, fields;
  int unsigned line_start, last_fall, field_start, de_t, vs_t, cs_t;

  always @(negedge clk) begin
    if (!rst && !started) begin
      started = 1;
      t0 = cyc; line_start = cyc; last_fall = cyc; field_start = cyc;
      fi = 0; line = 0; dots = 0; de_lines = 0; vint_cnt = 0; fields = 0;
      // R1 reset state
      chk(hsync_n == 1'b0, "R1 hsync_n", hsync_n, 0);
      chk(vsync_n == 1'b1, "R1 vsync_n", vsync_n, 1);
      chk(csync_n == 1'b0, "R1 csync_n", csync_n, 0);
      chk(disp_en == 1'b0, "R1 disp_en", disp_en, 0);
      chk(vint_req == 1'b0, "R1 vint_req", vint_req, 0);
      chk(dot_ce == 1'b0, "R1 dot_ce", dot_ce, 0);
    end else if (started) begin
      // horizontal sync falls: line spacing and dot count
      if (p_hs && !hsync_n) begin
        if (fi < 2*NEQ) begin
          chk(cyc - last_fall == GAP_HALF, "R4 half-line gap", cyc - last_fall, GAP_HALF);
          chk(dots == 420, "R4 dots per half line", dots, 420);
        end else begin
          chk(cyc - last_fall == L_FULL, "R2 line clocks", cyc - last_fall, L_FULL);
          chk(dots == 840, "R2 dots per line", dots, 840);
        end
        dots = 0;
        last_fall = cyc;
        fi = (fi + 1) % FALLS;
        if (fi < 2*NEQ) begin
          if (fi % 2 == 0) begin line = fi / 2; line_start = cyc; end
        end else begin
          line = fi - NEQ; line_start = cyc;
        end
        if (fi == 0) begin
          chk(cyc - field_start == FIELD, "R10 field clocks", cyc - field_start, FIELD);
          chk(de_lines == NACT, "R5 picture lines", de_lines, NACT);
          chk(vint_cnt == 1, "R8 requests per field", vint_cnt, 1);
          field_start = cyc; de_lines = 0; vint_cnt = 0; fields++;
        end
      end
      dots += int'(dot_ce);
      // sync release: pulse width
      if (!p_hs && hsync_n) begin
        if (line < NEQ) chk(cyc - last_fall == P_HALF, "R4 half pulse", cyc - last_fall, P_HALF);
        else            chk(cyc - last_fall == P_FULL, "R3 full pulse", cyc - last_fall, P_FULL);
      end
      // display enable
      if (!p_de && disp_en) begin
        chk(line >= NFIRST && line < VLINE, "R5 picture row", line, NFIRST);
        chk(cyc - line_start == DE_OFF, "R5 picture start", cyc - line_start, DE_OFF);
        de_t = cyc; de_lines++;
      end
      if (p_de && !disp_en)
        chk(cyc - de_t == DE_W, "R5 picture width", cyc - de_t, DE_W);
      // vertical sync
      if (p_vs && !vsync_n) begin
        chk(line == 3, "R6 vsync first line", line, 3);
        chk(cyc == line_start, "R6 vsync aligned fall", cyc - line_start, 0);
        vs_t = cyc;
      end
      if (!p_vs && vsync_n) begin
        chk(line == 3 + NBRD, "R6 vsync end line", line, 3 + NBRD);
        chk(cyc - vs_t == VS_W, "R6 vsync width", cyc - vs_t, VS_W);
      end
      // composite sync
      if (vsync_n) chk(csync_n == hsync_n, "R7 csync follows hsync", csync_n, hsync_n);
      else begin
        if (!hsync_n) chk(csync_n == 1'b0, "R7 csync and", csync_n, 0);
        if (!p_cs && csync_n) cs_t = cyc;
      end
      if (!p_vs && p_cs && !csync_n)
        chk(cyc - cs_t == SERR, "R7 serration width", cyc - cs_t, SERR);
      // vertical interrupt
      if (!p_irq && vint_req) begin
        chk(line == VLINE, "R8 request line", line, VLINE);
        chk(cyc - line_start == VI_OFF, "R8 request dot", cyc - line_start, VI_OFF);
        vint_cnt++;
      end
      if (p_ack) begin
        if (p_irq) chk(vint_req == 1'b0, "R9 ack clears", vint_req, 0);
        else if (line == VLINE && cyc - line_start == VI_OFF)
          chk(vint_req == 1'b1, "R9 trigger beats ack", vint_req, 1);
        else chk(vint_req == 1'b0, "R9 idle ack ignored", vint_req, 0);
      end else if (p_irq) chk(vint_req == 1'b1, "R9 request held", vint_req, 1);
    end
    p_hs = hsync_n; p_vs = vsync_n; p_cs = csync_n; p_de = disp_en;
    p_irq = vint_req; p_ack = vint_ack;
  end

  task automatic pulse_ack();
    #1 vint_ack = 1'b1;
    @(posedge clk);
    #1 vint_ack = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd7331));
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    wait (started);
    // random acknowledges while nothing is pending
    while (cyc < t0 + 85000) begin
      repeat (1500 + ($urandom % 4500)) @(posedge clk);
      pulse_ack();
    end
    // corner: acknowledge sampled on the trigger edge itself
    while (cyc != t0 + TRIG_REL - 1) begin @(posedge clk); #1; end
    vint_ack = 1'b1;
    @(posedge clk);
    #1 vint_ack = 1'b0;
    // random hold, then a real acknowledge
    repeat (50 + ($urandom % 400)) @(posedge clk);
    pulse_ack();
    for (int k = 0; k < 3; k++) begin
      repeat (2000 + ($urandom % 2000)) @(posedge clk);
      pulse_ack();
    end
    while (cyc < t0 + FIELD + 3000) @(posedge clk);
    @(negedge clk);
    chk(fields >= 1, "R10 field wrap seen", fields, 1);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R10 actual=%0d expected=%0d", cyc, FIELD);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule